// File: doc/BRIEF.md
# Configurable Edge-Triggered Interrupt Capture

This block watches a set of asynchronous input pins and turns selected transitions on them into interrupt requests that are one clock wide. Each pin is first brought into the clock domain through a synchroniser chain. Its synchronised level is then compared with the level it had one cycle earlier. A per-channel control word chooses which transitions count: falling only, rising only, or both. An enable bit in the same word gates the request.

One additional channel serves a shared, non-maskable request line. A source-select bit in its control word routes either an internal timer request or that channel's own pin events onto the line. Software-side logic programs the channels through a simple write port: an address picks the channel and four data bits load its control word. Addresses beyond the last channel change nothing.

Top module: `pin_edge_irq`

## Requirements
- R1: While reset is held and on the first cycle after it, every `irq_o` bit is 0. All channels are disabled with polarity code 00 and source select 0, so `shr_irq_o` equals `timer_req_i`.
- R2: With enable (data bit 0) set and polarity code 00 (data bits 3:2), a high-to-low pin change raises the channel's request exactly SYNC_STAGES+1 rising clock edges after the change. A low-to-high change raises nothing.
- R3: Polarity code 01 raises a request for low-to-high changes only.
- R4: Polarity code 10 behaves exactly as code 00 and raises a request for high-to-low changes only.
- R5: Polarity code 11 raises a request for every change in either direction.
- R6: With the enable bit at 0, pin changes raise no request. A change seen while the channel was disabled raises no request when the channel is later enabled.
- R7: Each qualifying change yields exactly one request pulse of one cycle. A pin held at a steady level yields no further pulses, and a pin that toggles every cycle under code 11 yields one pulse per change.
- R8: Rewriting the polarity code or the enable bit while the pin is steady never raises a request.
- R9: For the shared channel, select bit (data bit 1) at 0 makes `shr_irq_o` follow `timer_req_i` in the same cycle and ignore `shr_pin_i`. Select bit at 1 makes `shr_irq_o` carry only the shared pin's qualified pulses and ignore `timer_req_i`.
- R10: For SYNC_STAGES+1 cycles after reset release no request is raised, even when a pin level differs from the synchroniser's reset value.
- R11: Write address k (0 to NUM_PINS-1) loads the control word of pin k, and address NUM_PINS loads the shared channel. A write to any higher address changes no channel's behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous maskable interrupt pins |
| shr_pin_i | input | 1 | Asynchronous pin of the shared channel |
| timer_req_i | input | 1 | Internal timer request, alternative source of the shared line |
| wr_en_i | input | 1 | Control write strobe |
| wr_addr_i | input | AW | Channel index of the write |
| wr_data_i | input | 4 | Control word: bit 0 enable, bit 1 source select, bits 3:2 polarity |
| irq_o | output | NUM_PINS | One-cycle request per maskable pin |
| shr_irq_o | output | 1 | Shared non-maskable request line |

## Verification
The bench builds the block with four maskable pins and a two-stage synchroniser. This gives five channels and a three-bit address, so addresses 5 to 7 exist and can be written to show they are ignored. With two stages the request latency is exactly three edges, which the bench samples cycle-exactly. The warm-up window is short enough to hit directly by holding a pin high through reset and enabling its channel on the first cycle after release. Four pins allow different polarity codes to run side by side against a queue-based model of sampled pin history.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
// eirq_pkg: shared types and helpers for the edge-triggered interrupt block.
// Assumes a 4-bit control word: [3:2] polarity, [1] source select, [0] enable.
package eirq_pkg;

    localparam int CTRL_W = 4;

    // Polarity codes; the two even codes both mean falling edge.
    typedef enum logic [1:0] {
        POL_FALL     = 2'b00,
        POL_RISE     = 2'b01,
        POL_FALL_ALT = 2'b10,
        POL_ANY      = 2'b11
    } pol_e;

    // Control word as laid out on the write port.
    typedef struct packed {
        logic [1:0] pol;
        logic       src;
        logic       en;
    } ctrl_t;

    // Decide whether the observed transition qualifies under a polarity code.
    function automatic logic edge_hit(input pol_e p, input logic rise, input logic fall);
        logic hit;
        unique case (p)
            POL_RISE: hit = rise;
            POL_ANY:  hit = rise | fall;
            default:  hit = fall;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/eirq_sync.sv
`timescale 1ns/1ps
// eirq_sync: multi-stage synchroniser for a bus of independent asynchronous bits.
// Assumes each bit is unrelated to the others; no bus coherence is implied.
// All stages clear to 0 on reset.
module eirq_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    // Shift the raw inputs through the chain of stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/eirq_edge_det.sv
`timescale 1ns/1ps
// eirq_edge_det: compares successive synchronised samples of one pin and emits a
// registered one-cycle request when the transition matches the polarity code.
// Assumes samp is already synchronous. armed stays low until samp carries
// real pin data, so the reset contents of the chain never count as an edge.
module eirq_edge_det
    import eirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic       samp,
    input  logic       en,
    input  logic [1:0] pol,
    output logic       irq
);

    logic prev_q;
    logic irq_q;
    logic rise;
    logic fall;

    assign rise = samp & ~prev_q;
    assign fall = ~samp & prev_q;

    // Remember the last sample; it is tracked even while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= samp;
    end

    // Register the gated, polarity-qualified request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= armed & en & edge_hit(pol_e'(pol), rise, fall);
    end

    assign irq = irq_q;

    // Even codes accept only falling edges (R2 for code 00).
    assert_fall_codes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !$past(pol[0])) |-> !$past(samp));

    assert_rise_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && $past(pol) == 2'b01) |-> $past(samp));

    assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(en));

    assert_warmup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(armed));

endmodule

// File: rtl/eirq_ctrl_regs.sv
`timescale 1ns/1ps
// eirq_ctrl_regs: per-channel control storage loaded from the write port.
// Assumes entry N_ENT-1 is the shared channel; only it keeps a source bit.
// Writes to addresses at or above N_ENT are dropped.
module eirq_ctrl_regs
    import eirq_pkg::*;
#(
    parameter int N_ENT = 5,
    parameter int AW    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [CTRL_W-1:0]   wr_data,
    output logic [N_ENT-1:0]    en_o,
    output logic [N_ENT-1:0][1:0] pol_o,
    output logic                src_o
);

    ctrl_t wcw;
    logic [N_ENT-1:0]      en_q;
    logic [N_ENT-1:0][1:0] pol_q;
    logic                  src_q;

    assign wcw = ctrl_t'(wr_data);

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        // Load enable and polarity of channel i when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[i]  <= 1'b0;
                pol_q[i] <= 2'b00;
            end else if (wr_en && wr_addr == AW'(i)) begin
                en_q[i]  <= wcw.en;
                pol_q[i] <= wcw.pol;
            end
        end
    end

    // Load the source select of the shared channel.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   src_q <= 1'b0;
        else if (wr_en && wr_addr == AW'(N_ENT - 1))  src_q <= wcw.src;
    end

    assign en_o  = en_q;
    assign pol_o = pol_q;
    assign src_o = src_q;

    assert_ignore_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > AW'(N_ENT - 1)) |=>
            ($stable(en_q) && $stable(pol_q) && $stable(src_q)));

endmodule

// File: rtl/pin_edge_irq.sv
`timescale 1ns/1ps
// pin_edge_irq: edge-triggered interrupt capture for NUM_PINS maskable pins
// plus one shared channel whose line is fed by a timer or by its own pin.
// Assumes asynchronous pins and a synchronous control write port.
module pin_edge_irq
    import eirq_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2,
    localparam int N_ENT      = NUM_PINS + 1,
    localparam int AW         = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                shr_pin_i,
    input  logic                timer_req_i,
    input  logic                wr_en_i,
    input  logic [AW-1:0]       wr_addr_i,
    input  logic [CTRL_W-1:0]   wr_data_i,
    output logic [NUM_PINS-1:0] irq_o,
    output logic                shr_irq_o
);

    localparam int WARM = SYNC_STAGES + 1;
    localparam int CW   = $clog2(WARM + 1);

    logic [N_ENT-1:0]      raw;
    logic [N_ENT-1:0]      samp;
    logic [N_ENT-1:0]      pulse;
    logic [N_ENT-1:0]      en;
    logic [N_ENT-1:0][1:0] pol;
    logic                  src_sel;
    logic [CW-1:0]         warm_q;
    logic                  armed;

    assign raw = {shr_pin_i, pin_i};

    eirq_sync #(.STAGES(SYNC_STAGES), .W(N_ENT)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (samp)
    );

    eirq_ctrl_regs #(.N_ENT(N_ENT), .AW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en_i),
        .wr_addr(wr_addr_i),
        .wr_data(wr_data_i),
        .en_o   (en),
        .pol_o  (pol),
        .src_o  (src_sel)
    );

    // Count cycles after reset until the chain and history hold real samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                  warm_q <= '0;
        else if (warm_q != CW'(WARM)) warm_q <= warm_q + 1'b1;
    end

    assign armed = (warm_q == CW'(WARM));

    for (genvar c = 0; c < N_ENT; c++) begin : g_ch
        eirq_edge_det u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .armed(armed),
            .samp (samp[c]),
            .en   (en[c]),
            .pol  (pol[c]),
            .irq  (pulse[c])
        );
    end

    assign irq_o     = pulse[NUM_PINS-1:0];
    assign shr_irq_o = src_sel ? pulse[NUM_PINS] : timer_req_i;

    // Nothing fires in the first cycle after reset (R1).
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(warm_q) == '0 |-> pulse == '0);

endmodule

// File: tb/sim_pin_edge_irq.sv
`timescale 1ns/1ps
// sim_pin_edge_irq: directed stimulus plus a queue-based cycle model of the pins.
module sim_pin_edge_irq;

    localparam int NP = 4;
    localparam int SS = 2;
    localparam int NE = NP + 1;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin = '0;
    logic          shr_pin = 1'b0;
    logic          timer_req = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [3:0]    wr_data = '0;
    logic [NP-1:0] irq_o;
    logic          shr_irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    pin_edge_irq #(.NUM_PINS(NP), .SYNC_STAGES(SS)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .shr_pin_i(shr_pin),
        .timer_req_i(timer_req), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .irq_o(irq_o), .shr_irq_o(shr_irq_o)
    );

    always #2.5 clk = ~clk;

    // Reference model: history of sampled pin levels plus mirrored configuration.
    logic [NE-1:0] hist [$];
    bit   [NE-1:0] m_irq;
    bit   [NE-1:0] m_en;
    bit   [1:0]    m_pol [NE];
    bit            m_src;

    function automatic bit want(bit [1:0] p, bit older, bit newer);
        if (older == newer) return 0;
        if (p == 2'b11) return 1;
        if (p == 2'b01) return newer;
        return !newer;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            m_irq = '0;
            m_en  = '0;
            m_src = 0;
            for (int i = 0; i < NE; i++) m_pol[i] = 2'b00;
        end else begin
            for (int c = 0; c < NE; c++) begin
                m_irq[c] = 0;
                if (hist.size() >= SS + 1)
                    m_irq[c] = m_en[c] &&
                        want(m_pol[c], hist[hist.size()-SS-1][c], hist[hist.size()-SS][c]);
            end
            if (wr_en && int'(wr_addr) < NE) begin
                m_en[wr_addr]  = wr_data[0];
                m_pol[wr_addr] = wr_data[3:2];
                if (int'(wr_addr) == NE - 1) m_src = wr_data[1];
            end
            hist.push_back({shr_pin, pin});
            if (hist.size() > 8) void'(hist.pop_front());
        end
    end

    // Per-cycle comparison and pulse bookkeeping, away from the active edge.
    int  pcnt [NE];
    int  runs = 0;
    bit  last0 = 0;
    always @(negedge clk) begin
        bit exp_s;
        exp_s = m_src ? m_irq[NP] : timer_req;
        checks += 2;
        if (irq_o !== m_irq[NP-1:0]) begin
            fails++;
            $display("FAIL model R2 R3 R4 R5 R6 irq_o actual=%b expected=%b t=%0t",
                     irq_o, m_irq[NP-1:0], $time);
        end
        if (shr_irq_o !== exp_s) begin
            fails++;
            $display("FAIL model R9 shr_irq_o actual=%b expected=%b t=%0t",
                     shr_irq_o, exp_s, $time);
        end
        for (int c = 0; c < NP; c++) pcnt[c] += int'(irq_o[c]);
        pcnt[NP] += int'(shr_irq_o);
        if (irq_o[0] && last0) runs++;
        last0 = irq_o[0];
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, logic [3:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic clr();
        for (int c = 0; c < NE; c++) pcnt[c] = 0;
        runs = 0;
    endtask

    task automatic setp(int c, logic v);
        pin[c] = v;
        step(6);
    endtask

    initial begin
        for (int c = 0; c < NE; c++) pcnt[c] = 0;
        // R1 and R10: reset with pin 3 high and the timer request high.
        pin[3] = 1'b1;
        timer_req = 1'b1;
        step(4);
        @(negedge clk);
        chk("R1 irq_o in reset", int'(irq_o), 0);
        chk("R1 shared follows timer in reset", int'(shr_irq_o), 1);
        step(0);
        rst_n = 1'b1;
        step(1);
        timer_req = 1'b0;
        wr(3, 4'b0101);
        clr();
        step(10);
        chk("R10 no pulse during warm-up", pcnt[3], 0);

        // R2: code 00 falling edge and its latency.
        wr(0, 4'b0001);
        setp(0, 1'b1);
        clr();
        pin[0] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 no request before latency", int'(irq_o[0]), 0);
        @(negedge clk);
        chk("R2 request at SYNC_STAGES+1 edges", int'(irq_o[0]), 1);
        step(6);
        setp(0, 1'b1);
        chk("R2 falling only", pcnt[0], 1);

        // R3: code 01 rising edge only.
        wr(1, 4'b0101);
        clr();
        setp(1, 1'b1);
        setp(1, 1'b0);
        chk("R3 rising only", pcnt[1], 1);

        // R4: code 10 falling edge only.
        wr(2, 4'b1001);
        clr();
        setp(2, 1'b1);
        setp(2, 1'b0);
        chk("R4 falling only", pcnt[2], 1);

        // R5: code 11 both edges.
        wr(0, 4'b1101);
        clr();
        setp(0, 1'b0);
        setp(0, 1'b1);
        setp(0, 1'b0);
        setp(0, 1'b1);
        chk("R5 both edges", pcnt[0], 4);

        // R7: steady level, then a pin toggling every cycle.
        clr();
        setp(0, 1'b0);
        step(20);
        chk("R7 one pulse for a held level", pcnt[0], 1);
        chk("R7 pulse one cycle wide", runs, 0);
        clr();
        for (int k = 0; k < 6; k++) begin
            pin[0] = ~pin[0];
            step(1);
        end
        step(6);
        chk("R7 one pulse per change", pcnt[0], 6);

        // R6: disabled channel, then enabled after the change.
        wr(1, 4'b0100);
        clr();
        setp(1, 1'b1);
        setp(1, 1'b0);
        setp(1, 1'b1);
        wr(1, 4'b0101);
        step(10);
        chk("R6 disabled and late enable", pcnt[1], 0);
        setp(1, 1'b0);
        setp(1, 1'b1);
        chk("R6 enabled again", pcnt[1], 1);

        // R8: rewriting the configuration under a steady pin.
        setp(2, 1'b1);
        clr();
        wr(2, 4'b0001); wr(2, 4'b0101); wr(2, 4'b1000);
        wr(2, 4'b1101); wr(2, 4'b0100); wr(2, 4'b1101);
        step(8);
        chk("R8 no pulse from config change", pcnt[2], 0);

        // R9: shared line routed to the timer.
        wr(4, 4'b1101);
        clr();
        timer_req = 1'b1;
        @(negedge clk);
        chk("R9 timer routed same cycle", int'(shr_irq_o), 1);
        step(1);
        timer_req = 1'b0;
        step(1);
        clr();
        setp(4, 1'b1);
        setp(4, 1'b0);
        chk("R9 pin ignored when timer selected", pcnt[NP], 0);
        // R9: shared line routed to the pin.
        wr(4, 4'b1111);
        timer_req = 1'b1;
        step(6);
        @(negedge clk);
        chk("R9 timer ignored when pin selected", int'(shr_irq_o), 0);
        step(0);
        clr();
        shr_pin = 1'b1; step(6);
        shr_pin = 1'b0; step(6);
        chk("R9 pin pulses on shared line", pcnt[NP], 2);
        timer_req = 1'b0;

        // R11: writes beyond the last channel are dropped.
        wr(3, 4'b0000);
        wr(5, 4'b1101); wr(6, 4'b1101); wr(7, 4'b1111);
        clr();
        setp(3, 1'b0);
        setp(3, 1'b1);
        setp(2, 1'b0);
        chk("R11 channel 3 stays disabled", pcnt[3], 0);
        chk("R11 channel 2 keeps its code", pcnt[2], 1);
        step(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule